// File: doc/BRIEF.md
# Block Data Word Swap and Packing Unit

This unit connects a 32-bit register bus to a 128-bit block cipher datapath. Input words are written one at a time and each one passes through a swap network chosen by a 2-bit data-type field. The unit gathers four such words into a 128-bit block, filling from the most significant word down. When the fourth word arrives, the unit hands the block to the core with a one-cycle start strobe.

A registered stand-in takes the place of the core. It combines the block with the key and initialization-vector registers. Those registers are loaded word by word with no swap applied. When the core reports completion, a computation-complete flag goes up. Software then reads the result as four 32-bit words, most significant first, and each word passes through the same swap that was used on input. Because every swap mode undoes itself, data that goes in and comes back out with an all-zero key and vector is returned unchanged.

Top module: `aes_word_packer`

## Requirements
- R1: Four accepted writes on `din_i` form one block. The first word lands in bits [127:96], and each following word lands in the next lower 32-bit slot.
- R2: Each input word is swapped according to `dtype_i`:
  - 2'b00: no swap.
  - 2'b01: the two 16-bit halves are exchanged.
  - 2'b10: the byte order is reversed.
  - 2'b11: bit i moves to bit 31-i.
- R3: Reads on `dout_o` return result bits [127:96] first, then each lower 32-bit slot in turn.
- R4: The swap selected by `dtype_i` is also applied to every output word, so input data returns unchanged when the key and vector are zero.
- R5: Writes to the key and vector words are stored without a swap in every mode. Index 0 addresses bits [127:96] and `kiv_sel_i`=1 selects the vector. The stand-in result is block XOR key XOR vector.
- R6: `ccf_o` rises at the second rising edge after the edge at which `start_o` went high.
- R7: A `ccf_clr_i` pulse lowers `ccf_o`, and the next result is read starting from bits [127:96].
- R8: While `ccf_o` is low, `dout_o` is zero and read pulses do not advance the read position.
- R9: While `en_i` is low, `ccf_o` is cleared, both word positions return to zero and data writes are ignored.
- R10: `start_o` is high for exactly one cycle, starting at the rising edge that accepts the fourth word. `blk_o` holds the assembled block while `start_o` is high, and the next write starts a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enable |
| dtype_i | input | 2 | Swap mode select |
| din_we_i | input | 1 | Data word write strobe |
| din_i | input | 32 | Data word in |
| dout_re_i | input | 1 | Result word read strobe |
| dout_o | output | 32 | Result word out, swapped |
| kiv_we_i | input | 1 | Key or vector word write strobe |
| kiv_sel_i | input | 1 | 0 selects key, 1 selects vector |
| kiv_idx_i | input | 2 | Word index, 0 addresses the most significant word |
| kiv_data_i | input | 32 | Key or vector word, never swapped |
| ccf_clr_i | input | 1 | Clears the complete flag |
| ccf_o | output | 1 | Computation complete flag |
| start_o | output | 1 | One-cycle start strobe to the core |
| blk_o | output | 128 | Assembled block presented to the core |

## Verification
`start_o` and `blk_o` change at the edge that accepts the fourth word. The core's done pulse comes one edge later, and `ccf_o` one edge after that. `dout_o` is combinational from the read position and the flag, so it is valid in the same cycle as the state it reflects. The bench drives inputs and samples outputs on falling edges. It therefore checks the strobe at the first falling edge after the last write and the flag two falling edges later. It checks each read word before pulsing the read strobe for that word.

// File: rtl/wswap_pkg.sv
package wswap_pkg;
  typedef enum logic [1:0] {
    DT_NONE = 2'b00,
    DT_HALF = 2'b01,
    DT_BYTE = 2'b10,
    DT_BIT  = 2'b11
  } dtype_e;
endpackage

// File: rtl/aes_word_swap.sv
module aes_word_swap
  import wswap_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  dtype_e            mode_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] half_sw, byte_sw, bit_sw;

  assign half_sw = {word_i[HALF_W-1:0], word_i[WORD_W-1:HALF_W]};

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_sw[8*b +: 8] = word_i[WORD_W-8*(b+1) +: 8];
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign bit_sw[i] = word_i[WORD_W-1-i];
  end

  always_comb begin
    unique case (mode_i)
      DT_HALF: word_o = half_sw;
      DT_BYTE: word_o = byte_sw;
      DT_BIT:  word_o = bit_sw;
      default: word_o = word_i;
    endcase
  end
endmodule

// File: rtl/aes_din_packer.sv
module aes_din_packer #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    we_i,
  input  logic [WORD_W-1:0]       word_i,
  output logic                    start_o,
  output logic [WORD_W*WORDS-1:0] blk_o
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int ACC_W = BLK_W - WORD_W;
  localparam int CNT_W = $clog2(WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      blk_o   <= '0;
      start_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (we_i) begin
        if (cnt_q == LAST) begin
          // earlier words already sit in the upper slots of acc_q
          blk_o   <= {acc_q, word_i};
          start_o <= 1'b1;
          cnt_q   <= '0;
        end else begin
          acc_q <= {acc_q[ACC_W-WORD_W-1:0], word_i};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aes_core_stub.sv
module aes_core_stub #(
  parameter int BLK_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic [BLK_W-1:0] iv_i,
  output logic             done_o,
  output logic [BLK_W-1:0] res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      res_o  <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) res_o <= blk_i ^ key_i ^ iv_i;
    end
  end
endmodule

// File: rtl/aes_dout_unpacker.sv
module aes_dout_unpacker #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         done_i,
  input  logic                         clr_i,
  input  logic                         re_i,
  input  logic [WORD_W*WORDS-1:0]      res_i,
  output logic                         ccf_o,
  output logic [$clog2(WORDS)-1:0]     rd_cnt_o,
  output logic [WORD_W-1:0]            word_o
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int CNT_W = $clog2(WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccf_o    <= 1'b0;
      rd_cnt_o <= '0;
    end else if (!en_i) begin
      ccf_o    <= 1'b0;
      rd_cnt_o <= '0;
    end else if (done_i) begin
      ccf_o    <= 1'b1;
      rd_cnt_o <= '0;
    end else if (clr_i) begin
      ccf_o    <= 1'b0;
      rd_cnt_o <= '0;
    end else if (re_i && ccf_o) begin
      rd_cnt_o <= (rd_cnt_o == LAST) ? '0 : rd_cnt_o + 1'b1;
    end
  end

  always_comb begin
    word_o = '0;
    if (ccf_o) word_o = res_i[BLK_W-1-WORD_W*int'(rd_cnt_o) -: WORD_W];
  end
endmodule

// File: rtl/aes_word_packer.sv
module aes_word_packer
  import wswap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [1:0]                   dtype_i,
  input  logic                         din_we_i,
  input  logic [WORD_W-1:0]            din_i,
  input  logic                         dout_re_i,
  output logic [WORD_W-1:0]            dout_o,
  input  logic                         kiv_we_i,
  input  logic                         kiv_sel_i,
  input  logic [$clog2(WORDS)-1:0]     kiv_idx_i,
  input  logic [WORD_W-1:0]            kiv_data_i,
  input  logic                         ccf_clr_i,
  output logic                         ccf_o,
  output logic                         start_o,
  output logic [WORD_W*WORDS-1:0]      blk_o
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int IDX_W = $clog2(WORDS);

  dtype_e              mode;
  logic [WORD_W-1:0]   din_sw, res_word;
  logic [BLK_W-1:0]    key_q, iv_q, res;
  logic                core_done;
  logic [IDX_W-1:0]    rd_cnt;

  assign mode = dtype_e'(dtype_i);

  aes_word_swap #(.WORD_W(WORD_W)) u_sw_in (
    .mode_i(mode), .word_i(din_i), .word_o(din_sw)
  );

  aes_din_packer #(.WORD_W(WORD_W), .WORDS(WORDS)) u_pack (
    .clk_i, .rst_ni, .en_i,
    .we_i(din_we_i), .word_i(din_sw),
    .start_o, .blk_o
  );

  // key and vector words bypass the swap network
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      iv_q  <= '0;
    end else if (kiv_we_i) begin
      if (kiv_sel_i) iv_q[BLK_W-WORD_W*(int'(kiv_idx_i)+1) +: WORD_W]  <= kiv_data_i;
      else           key_q[BLK_W-WORD_W*(int'(kiv_idx_i)+1) +: WORD_W] <= kiv_data_i;
    end
  end

  aes_core_stub #(.BLK_W(BLK_W)) u_core (
    .clk_i, .rst_ni,
    .start_i(start_o), .blk_i(blk_o), .key_i(key_q), .iv_i(iv_q),
    .done_o(core_done), .res_o(res)
  );

  aes_dout_unpacker #(.WORD_W(WORD_W), .WORDS(WORDS)) u_unpack (
    .clk_i, .rst_ni, .en_i,
    .done_i(core_done), .clr_i(ccf_clr_i), .re_i(dout_re_i),
    .res_i(res), .ccf_o, .rd_cnt_o(rd_cnt), .word_o(res_word)
  );

  aes_word_swap #(.WORD_W(WORD_W)) u_sw_out (
    .mode_i(mode), .word_i(res_word), .word_o(dout_o)
  );
endmodule

// File: rtl/aes_word_packer_chk.sv
module aes_word_packer_chk #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              ccf_clr_i,
  input logic              ccf_o,
  input logic              start_o,
  input logic [WORD_W-1:0] dout_o,
  input logic              core_done,
  input logic [IDX_W-1:0]  rd_cnt
);
  a_r10_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r6_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> core_done);

  a_r6_flag_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && core_done |=> ccf_o);

  a_r7_clear_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ccf_clr_i && !core_done |=> !ccf_o);

  a_r8_zero_before_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ccf_o |-> dout_o == '0);

  a_r8_read_pos_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ccf_o |-> rd_cnt == '0);

  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ccf_o && !start_o);
endmodule

bind aes_word_packer aes_word_packer_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .ccf_clr_i, .ccf_o, .start_o, .dout_o,
  .core_done(core_done), .rd_cnt(rd_cnt)
);

// File: tb/tb_aes_word_packer.sv
module tb_aes_word_packer;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [1:0]   dtype_i = 2'b00;
  logic         din_we_i = 1'b0;
  logic [31:0]  din_i = '0;
  logic         dout_re_i = 1'b0;
  logic [31:0]  dout_o;
  logic         kiv_we_i = 1'b0;
  logic         kiv_sel_i = 1'b0;
  logic [1:0]   kiv_idx_i = '0;
  logic [31:0]  kiv_data_i = '0;
  logic         ccf_clr_i = 1'b0;
  logic         ccf_o;
  logic         start_o;
  logic [127:0] blk_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  aes_word_packer dut (
    .clk_i, .rst_ni, .en_i, .dtype_i, .din_we_i, .din_i, .dout_re_i, .dout_o,
    .kiv_we_i, .kiv_sel_i, .kiv_idx_i, .kiv_data_i, .ccf_clr_i, .ccf_o,
    .start_o, .blk_o
  );

  function automatic logic [31:0] sw(input logic [1:0] m, input logic [31:0] w);
    logic [31:0] r;
    case (m)
      2'b01: r = {w[15:0], w[31:16]};
      2'b10: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'b11: for (int i = 0; i < 32; i++) r[i] = w[31-i];
      default: r = w;
    endcase
    return r;
  endfunction

  function automatic logic [127:0] swblk(input logic [1:0] m, input logic [127:0] b);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[32*i +: 32] = sw(m, b[32*i +: 32]);
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_words(input logic [127:0] raw);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      din_we_i = 1'b1;
      din_i = raw[127-32*i -: 32];
    end
    @(negedge clk_i);
    din_we_i = 1'b0;
  endtask

  task automatic wait_flag();
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic read_word(output logic [31:0] w);
    w = dout_o;
    dout_re_i = 1'b1;
    @(negedge clk_i);
    dout_re_i = 1'b0;
  endtask

  task automatic clear_flag();
    ccf_clr_i = 1'b1;
    @(negedge clk_i);
    ccf_clr_i = 1'b0;
  endtask

  task automatic kiv_write(input logic sel, input logic [127:0] v);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      kiv_we_i = 1'b1;
      kiv_sel_i = sel;
      kiv_idx_i = 2'(i);
      kiv_data_i = v[127-32*i -: 32];
    end
    @(negedge clk_i);
    kiv_we_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 reset ccf", 128'(ccf_o), 128'(0));
    check("R10 reset start", 128'(start_o), 128'(0));
    check("R8 reset dout", 128'(dout_o), 128'(0));
  endtask

  task automatic t_pack();
    logic [127:0] raw = 128'h11223344_55667788_99aabbcc_ddeeff00;
    dtype_i = 2'b00;
    put_words(raw);
    check("R10 start high", 128'(start_o), 128'(1));
    check("R1 block order", blk_o, raw);
    @(negedge clk_i);
    check("R10 start one cycle", 128'(start_o), 128'(0));
    check("R6 flag not yet", 128'(ccf_o), 128'(0));
    @(negedge clk_i);
    check("R6 flag raised", 128'(ccf_o), 128'(1));
    clear_flag();
  endtask

  task automatic t_swap_in();
    logic [127:0] raw = 128'h01234567_89abcdef_fedcba98_0f1e2d3c;
    for (int m = 1; m < 4; m++) begin
      dtype_i = 2'(m);
      put_words(raw);
      check($sformatf("R2 input swap mode %0d", m), blk_o, swblk(2'(m), raw));
      wait_flag();
      clear_flag();
    end
  endtask

  task automatic t_roundtrip();
    logic [127:0] raw = 128'hcafef00d_12345678_a5a5c3c3_00ff8001;
    logic [31:0] w;
    for (int m = 0; m < 4; m++) begin
      dtype_i = 2'(m);
      put_words(raw);
      wait_flag();
      for (int i = 0; i < 4; i++) begin
        read_word(w);
        check($sformatf("R3 R4 read word %0d mode %0d", i, m), 128'(w), 128'(raw[127-32*i -: 32]));
      end
      clear_flag();
    end
  endtask

  task automatic t_keyiv();
    logic [127:0] k = 128'h00010203_04050607_08090a0b_0c0d0e0f;
    logic [127:0] v = 128'hf0e0d0c0_b0a09080_70605040_30201000;
    logic [31:0] w;
    dtype_i = 2'b10;
    kiv_write(1'b0, k);
    put_words('0);
    wait_flag();
    for (int i = 0; i < 4; i++) begin
      read_word(w);
      check($sformatf("R5 key word %0d", i), 128'(w), 128'(sw(2'b10, k[127-32*i -: 32])));
    end
    clear_flag();
    kiv_write(1'b0, '0);
    dtype_i = 2'b11;
    kiv_write(1'b1, v);
    put_words('0);
    wait_flag();
    read_word(w);
    check("R5 vector word 0", 128'(w), 128'(sw(2'b11, v[127:96])));
    clear_flag();
    kiv_write(1'b1, '0);
  endtask

  task automatic t_clear();
    logic [127:0] a = 128'h11111111_22222222_33333333_44444444;
    logic [127:0] b = 128'haaaaaaaa_bbbbbbbb_cccccccc_dddddddd;
    logic [31:0] w;
    dtype_i = 2'b00;
    put_words(a);
    wait_flag();
    read_word(w);
    read_word(w);
    clear_flag();
    check("R7 flag cleared", 128'(ccf_o), 128'(0));
    check("R7 dout zero after clear", 128'(dout_o), 128'(0));
    put_words(b);
    wait_flag();
    read_word(w);
    check("R7 read restarts at top", 128'(w), 128'(b[127:96]));
    clear_flag();
  endtask

  task automatic t_early();
    logic [127:0] a = 128'h5a5a0001_5a5a0002_5a5a0003_5a5a0004;
    logic [31:0] w;
    dtype_i = 2'b00;
    read_word(w);
    check("R8 early read zero", 128'(w), 128'(0));
    read_word(w);
    put_words(a);
    @(negedge clk_i);
    check("R8 zero while flag low", 128'(dout_o), 128'(0));
    @(negedge clk_i);
    read_word(w);
    check("R8 no advance before flag", 128'(w), 128'(a[127:96]));
    clear_flag();
  endtask

  task automatic t_enable();
    logic [127:0] a = 128'hdeadbeef_00000001_00000002_00000003;
    logic [31:0] w;
    dtype_i = 2'b00;
    put_words(a);
    wait_flag();
    read_word(w);
    en_i = 1'b0;
    @(negedge clk_i);
    check("R9 flag cleared by disable", 128'(ccf_o), 128'(0));
    en_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk_i);
      din_we_i = 1'b1;
      din_i = 32'hbad00000 + 32'(i);
    end
    @(negedge clk_i);
    din_we_i = 1'b0;
    en_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      din_we_i = 1'b1;
      din_i = 32'hbad10000 + 32'(i);
    end
    @(negedge clk_i);
    din_we_i = 1'b0;
    check("R9 no start while disabled", 128'(start_o), 128'(0));
    en_i = 1'b1;
    put_words(a);
    check("R9 start after reenable", 128'(start_o), 128'(1));
    check("R9 counter reset by disable", blk_o, a);
    wait_flag();
    read_word(w);
    check("R9 read position reset", 128'(w), 128'(a[127:96]));
    clear_flag();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    en_i = 1'b1;
    @(negedge clk_i);
    t_pack();
    t_swap_in();
    t_roundtrip();
    t_keyiv();
    t_clear();
    t_early();
    t_enable();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule